// File: doc/BRIEF.md
# Endpoint Status Flag Unit

This block keeps the status flags of one high-speed USB device endpoint. It has four flag bits, and three of them are shared: what sets or clears a shared bit depends on the configured endpoint kind. The kinds are control, bulk/interrupt, isochronous IN and isochronous OUT. An isochronous endpoint counts as high-bandwidth when it is configured for more than one transaction per microframe. The protocol engine sends one-cycle event strobes, a microframe-end pulse, and per-bank strobes that mark a bank as validated or transmitted. Firmware sends one-cycle clear strobes. An endpoint-reset or endpoint-disable strobe wipes all state.

Each flag is a register. A strobe seen at a clock edge shows in `statusWord` after that edge. The endpoint kind (`epKind`) and the transactions-per-microframe value (`nbTrans`) are static configuration. Changing them does not change flags that are already set.

Status bits: bit 0 is the SETUP/error-flow flag, bit 1 the stall/CRC/transaction-count flag, bit 2 the NAK-IN flag, and bit 3 the toggle-sequence error flag. Endpoint kind codes: 0 control, 1 bulk/interrupt, 2 isochronous IN, 3 isochronous OUT.

Top module: `ep_status_flags`

## Requirements
- R1: After reset `statusWord` is 0.
- R2: On a control endpoint (kind 0), `evSetup` sets bit 0, and `fwClrFlow` clears it.
- R3: Bit 0 is also set by `evInUnderflow` on kind 2 and by `evOutOverflow` on kind 3. Any of these three events on any other kind leaves bit 0 unchanged.
- R4: On kinds 0 and 1, `evStallSent` sets bit 1 and `fwClrStall` clears it. On kinds 2 and 3, `evStallSent` has no effect.
- R5: On kind 3, each `evOutData` loads bit 1 with `outCrcBad`, and `fwClrStall` has no effect on it.
- R6: On kind 2, a `mfEnd` pulse sets bit 1 when at least one bank was transmitted in the microframe and fewer banks than `nbTrans` (1 to 3) were validated. Bank strobes that arrive in the same cycle as `mfEnd` count toward the microframe that is ending.
- R7: The validated-bank and transmitted-bank counts restart from zero after every `mfEnd`. Each count saturates at 3.
- R8: `evNakIn` sets bit 2 and `fwClrNak` clears it.
- R9: On kind 3 with `nbTrans` of 2 or more, `evOutData` with `outToggleBad` high sets bit 3, and `evOutData` with `outToggleBad` low clears it. On any other configuration bit 3 stays 0.
- R10: When a set event and a firmware clear for the same bit arrive in the same cycle, the bit ends up set.
- R11: `epReset` or `epDisable` clears all flags and both bank counts. It overrides any set event in the same cycle.
- R12: Changing `epKind` or `nbTrans` does not alter flags that are already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| epKind | input | 2 | Endpoint kind (0 control, 1 bulk/int, 2 iso IN, 3 iso OUT) |
| nbTrans | input | 2 | Transactions per microframe, 1 to 3 |
| evSetup | input | 1 | Valid SETUP packet received |
| evInUnderflow | input | 1 | Isochronous IN bank not filled in time |
| evOutOverflow | input | 1 | Isochronous OUT data dropped, bank busy |
| evStallSent | input | 1 | STALL handshake sent on request |
| evNakIn | input | 1 | NAK sent in reply to an IN token |
| evOutData | input | 1 | New OUT data received |
| outCrcBad | input | 1 | CRC status of that OUT data, qualifies evOutData |
| outToggleBad | input | 1 | Current bank holds a bad n-transaction, qualifies evOutData |
| mfEnd | input | 1 | Microframe-end pulse |
| bankValid | input | 1 | A bank was validated for transmit |
| bankSent | input | 1 | A bank was transmitted |
| fwClrFlow | input | 1 | Firmware clear of bit 0 |
| fwClrStall | input | 1 | Firmware clear of bit 1 |
| fwClrNak | input | 1 | Firmware clear of bit 2 |
| epReset | input | 1 | Endpoint reset strobe |
| epDisable | input | 1 | Endpoint disable strobe |
| statusWord | output | 4 | Packed status flags |

## Verification
The hardest state to reach is the transaction-count error. It depends on the two hidden bank counts, on `nbTrans`, and on strobes that coincide with `mfEnd`. None of these can be seen at the ports. The bench therefore sweeps every `nbTrans` value against every validated and transmitted count from 0 to 4, with the counts built up over separate cycles. It then repeats the sweep with the last bank strobe placed in the `mfEnd` cycle, and compares bit 1 with the formula computed in the bench. To show that the counts were really cleared, it pulses a reset or disable and then a bare `mfEnd`, and checks that bit 1 stays low.

// File: rtl/ep_status_pkg.sv
package ep_status_pkg;
  localparam int STATUS_W = 4;
  localparam int BIT_FLOW  = 0;
  localparam int BIT_STALL = 1;
  localparam int BIT_NAK   = 2;
  localparam int BIT_TOG   = 3;

  typedef enum logic [1:0] {
    KIND_CTRL    = 2'd0,
    KIND_BULKINT = 2'd1,
    KIND_ISO_IN  = 2'd2,
    KIND_ISO_OUT = 2'd3
  } epKind_e;

  typedef struct packed {
    logic clrAll;
    logic setFlow;
    logic clrFlow;
    logic setStall;
    logic clrStall;
    logic loadCrc;
    logic crcVal;
    logic setNak;
    logic clrNak;
    logic setTog;
    logic clrTog;
  } flagStrb_t;
endpackage

// File: rtl/ep_status_ctrl.sv
module ep_status_ctrl
  import ep_status_pkg::*;
#(
  parameter int MAX_TRANS = 3,
  localparam int CNT_W = $clog2(MAX_TRANS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       epKind,
  input  logic [CNT_W-1:0] nbTrans,
  input  logic             evSetup,
  input  logic             evInUnderflow,
  input  logic             evOutOverflow,
  input  logic             evStallSent,
  input  logic             evNakIn,
  input  logic             evOutData,
  input  logic             outCrcBad,
  input  logic             outToggleBad,
  input  logic             mfEnd,
  input  logic             bankValid,
  input  logic             bankSent,
  input  logic             fwClrFlow,
  input  logic             fwClrStall,
  input  logic             fwClrNak,
  input  logic             epReset,
  input  logic             epDisable,
  output flagStrb_t        strb
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_TRANS);

  logic [CNT_W-1:0] validCnt, sentCnt;
  logic [CNT_W:0]   validEff, sentEff;
  logic isCtrl, isBulk, isIsoIn, isIsoOut, highBw, wipe, cntErr;

  assign isCtrl   = (epKind == KIND_CTRL);
  assign isBulk   = (epKind == KIND_BULKINT);
  assign isIsoIn  = (epKind == KIND_ISO_IN);
  assign isIsoOut = (epKind == KIND_ISO_OUT);
  assign highBw   = (nbTrans > CNT_W'(1));
  assign wipe     = epReset | epDisable;

  // same-cycle bank strobes belong to the microframe that is closing
  assign validEff = {1'b0, validCnt} + (CNT_W+1)'(bankValid);
  assign sentEff  = {1'b0, sentCnt} + (CNT_W+1)'(bankSent);
  assign cntErr   = mfEnd & isIsoIn & (sentEff != '0) & (validEff < {1'b0, nbTrans});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validCnt <= '0;
      sentCnt  <= '0;
    end else if (wipe || mfEnd) begin
      validCnt <= '0;
      sentCnt  <= '0;
    end else begin
      if (bankValid && validCnt != CNT_MAX) validCnt <= validCnt + 1'b1;
      if (bankSent && sentCnt != CNT_MAX)   sentCnt  <= sentCnt + 1'b1;
    end
  end

  always_comb begin
    strb.clrAll   = wipe;
    strb.setFlow  = (isCtrl & evSetup) | (isIsoIn & evInUnderflow) | (isIsoOut & evOutOverflow);
    strb.clrFlow  = fwClrFlow;
    strb.setStall = ((isCtrl | isBulk) & evStallSent) | cntErr;
    strb.clrStall = fwClrStall & ~isIsoOut;
    strb.loadCrc  = isIsoOut & evOutData;
    strb.crcVal   = outCrcBad;
    strb.setNak   = evNakIn;
    strb.clrNak   = fwClrNak;
    strb.setTog   = isIsoOut & highBw & evOutData & outToggleBad;
    strb.clrTog   = isIsoOut & highBw & evOutData & ~outToggleBad;
  end

  // R7
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    mfEnd |=> (validCnt == '0 && sentCnt == '0));

  // R11
  cnt_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    wipe |=> (validCnt == '0 && sentCnt == '0));
endmodule

// File: rtl/ep_status_dp.sv
module ep_status_dp
  import ep_status_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  flagStrb_t           strb,
  output logic [STATUS_W-1:0] flags
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
    end else if (strb.clrAll) begin
      flags <= '0;
    end else begin
      if (strb.setFlow)       flags[BIT_FLOW] <= 1'b1;
      else if (strb.clrFlow)  flags[BIT_FLOW] <= 1'b0;

      if (strb.setStall)      flags[BIT_STALL] <= 1'b1;
      else if (strb.loadCrc)  flags[BIT_STALL] <= strb.crcVal;
      else if (strb.clrStall) flags[BIT_STALL] <= 1'b0;

      if (strb.setNak)        flags[BIT_NAK] <= 1'b1;
      else if (strb.clrNak)   flags[BIT_NAK] <= 1'b0;

      if (strb.setTog)        flags[BIT_TOG] <= 1'b1;
      else if (strb.clrTog)   flags[BIT_TOG] <= 1'b0;
    end
  end

  // R11
  wipe_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrAll |=> (flags == '0));

  // R10
  nak_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setNak && !strb.clrAll) |=> flags[BIT_NAK]);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clrAll && !strb.setStall && !strb.loadCrc && !strb.clrStall)
      |=> $stable(flags[BIT_STALL]));
endmodule

// File: rtl/ep_status_flags.sv
module ep_status_flags
  import ep_status_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          epKind,
  input  logic [1:0]          nbTrans,
  input  logic                evSetup,
  input  logic                evInUnderflow,
  input  logic                evOutOverflow,
  input  logic                evStallSent,
  input  logic                evNakIn,
  input  logic                evOutData,
  input  logic                outCrcBad,
  input  logic                outToggleBad,
  input  logic                mfEnd,
  input  logic                bankValid,
  input  logic                bankSent,
  input  logic                fwClrFlow,
  input  logic                fwClrStall,
  input  logic                fwClrNak,
  input  logic                epReset,
  input  logic                epDisable,
  output logic [STATUS_W-1:0] statusWord
);
  flagStrb_t strb;

  ep_status_ctrl #(.MAX_TRANS(3)) u_ctrl (
    .clk(clk), .rstN(rstN), .epKind(epKind), .nbTrans(nbTrans),
    .evSetup(evSetup), .evInUnderflow(evInUnderflow), .evOutOverflow(evOutOverflow),
    .evStallSent(evStallSent), .evNakIn(evNakIn), .evOutData(evOutData),
    .outCrcBad(outCrcBad), .outToggleBad(outToggleBad), .mfEnd(mfEnd),
    .bankValid(bankValid), .bankSent(bankSent), .fwClrFlow(fwClrFlow),
    .fwClrStall(fwClrStall), .fwClrNak(fwClrNak), .epReset(epReset),
    .epDisable(epDisable), .strb(strb)
  );

  ep_status_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .flags(statusWord)
  );

  // R9
  tog_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[BIT_TOG]) |-> ($past(epKind) == KIND_ISO_OUT && $past(nbTrans) > 2'd1));

  // R2
  flow_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[BIT_FLOW]) |-> $past(evSetup | evInUnderflow | evOutOverflow));
endmodule

// File: tb/ep_status_flags_bench.sv
module ep_status_flags_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] epKind = 2'd0, nbTrans = 2'd1;
  logic evSetup = 0, evInUnderflow = 0, evOutOverflow = 0, evStallSent = 0, evNakIn = 0;
  logic evOutData = 0, outCrcBad = 0, outToggleBad = 0, mfEnd = 0, bankValid = 0, bankSent = 0;
  logic fwClrFlow = 0, fwClrStall = 0, fwClrNak = 0, epReset = 0, epDisable = 0;
  logic [3:0] statusWord;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  ep_status_flags u_ep_status_flags (.*);

  task automatic idleAll();
    evSetup = 0; evInUnderflow = 0; evOutOverflow = 0; evStallSent = 0; evNakIn = 0;
    evOutData = 0; outCrcBad = 0; outToggleBad = 0; mfEnd = 0; bankValid = 0; bankSent = 0;
    fwClrFlow = 0; fwClrStall = 0; fwClrNak = 0; epReset = 0; epDisable = 0;
  endtask

  // strobes set before the call are captured at the next edge, then dropped
  task automatic step();
    @(posedge clk); @(negedge clk);
    idleAll();
  endtask

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: statusWord=%b expected %b", req, act, exp);
    end
  endtask

  task automatic wipeEp();
    epReset = 1; step();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks + 1);
    $finish;
  end

  initial begin : stim
    repeat (2) @(negedge clk);
    // R1
    check("R1", statusWord, 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", statusWord, 4'b0000);

    // R2 / R3: every kind against every bit-0 event
    for (int k = 0; k < 4; k++) begin
      for (int e = 0; e < 3; e++) begin
        wipeEp();
        epKind = 2'(k);
        evSetup = (e == 0); evInUnderflow = (e == 1); evOutOverflow = (e == 2);
        step();
        check("R3", statusWord,
              {3'b000, (k == 0 && e == 0) || (k == 2 && e == 1) || (k == 3 && e == 2)});
        fwClrFlow = 1; step();
        check("R2", statusWord, 4'b0000);
      end
    end

    // R4
    for (int k = 0; k < 4; k++) begin
      wipeEp();
      epKind = 2'(k);
      evStallSent = 1; step();
      check("R4", statusWord, {2'b00, k < 2, 1'b0});
      fwClrStall = 1; step();
      check("R4", statusWord, 4'b0000);
    end

    // R5
    wipeEp();
    epKind = 2'd3; nbTrans = 2'd1;
    evOutData = 1; outCrcBad = 1; step();
    check("R5", statusWord, 4'b0010);
    fwClrStall = 1; step();
    check("R5", statusWord, 4'b0010);
    evOutData = 1; outCrcBad = 0; step();
    check("R5", statusWord, 4'b0000);

    // R6 / R7: counts built over separate cycles, last strobe optionally on mfEnd
    epKind = 2'd2;
    for (int sameCyc = 0; sameCyc < 2; sameCyc++) begin
      for (int nb = 1; nb <= 3; nb++) begin
        for (int v = 0; v <= 4; v++) begin
          for (int s = 0; s <= 4; s++) begin
            int vPre, sPre, vEff, sEff;
            wipeEp();
            nbTrans = 2'(nb);
            vPre = (sameCyc == 1 && v > 0) ? v - 1 : v;
            sPre = (sameCyc == 1 && s > 0) ? s - 1 : s;
            for (int i = 0; i < vPre; i++) begin bankValid = 1; step(); end
            for (int i = 0; i < sPre; i++) begin bankSent = 1; step(); end
            mfEnd = 1;
            bankValid = (sameCyc == 1 && v > 0);
            bankSent  = (sameCyc == 1 && s > 0);
            step();
            vEff = (vPre > 3 ? 3 : vPre) + ((sameCyc == 1 && v > 0) ? 1 : 0);
            sEff = sPre + ((sameCyc == 1 && s > 0) ? 1 : 0);
            check("R6", statusWord, {2'b00, (sEff >= 1) && (vEff < nb), 1'b0});
            // R7: after restart an empty microframe raises nothing new
            fwClrStall = 1; step();
            mfEnd = 1; step();
            check("R7", statusWord, 4'b0000);
          end
        end
      end
    end

    // R8
    wipeEp();
    epKind = 2'd1;
    evNakIn = 1; step();
    check("R8", statusWord, 4'b0100);
    fwClrNak = 1; step();
    check("R8", statusWord, 4'b0000);

    // R9
    for (int k = 2; k < 4; k++) begin
      for (int nb = 1; nb <= 3; nb++) begin
        wipeEp();
        epKind = 2'(k); nbTrans = 2'(nb);
        evOutData = 1; outToggleBad = 1; step();
        check("R9", statusWord, {(k == 3 && nb > 1), 3'b000});
        evOutData = 1; outToggleBad = 0; step();
        check("R9", statusWord, 4'b0000);
      end
    end

    // R10
    wipeEp();
    epKind = 2'd0;
    evSetup = 1; fwClrFlow = 1; evNakIn = 1; fwClrNak = 1; evStallSent = 1; fwClrStall = 1;
    step();
    check("R10", statusWord, 4'b0111);

    // R11: wipe beats sets, and drops the bank counts
    epReset = 1; evNakIn = 1; evSetup = 1; step();
    check("R11", statusWord, 4'b0000);
    epKind = 2'd3; nbTrans = 2'd2;
    evOutData = 1; outToggleBad = 1; step();
    evNakIn = 1; step();
    epDisable = 1; step();
    check("R11", statusWord, 4'b0000);
    epKind = 2'd2; nbTrans = 2'd1;
    bankSent = 1; step();
    epDisable = 1; step();
    mfEnd = 1; step();
    check("R11", statusWord, 4'b0000);

    // R12
    wipeEp();
    epKind = 2'd3; nbTrans = 2'd3;
    evOutData = 1; outToggleBad = 1; outCrcBad = 1; step();
    evOutOverflow = 1; step();
    check("R12", statusWord, 4'b1011);
    epKind = 2'd0; nbTrans = 2'd1; step();
    check("R12", statusWord, 4'b1011);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule